// File: doc/BRIEF.md
# Hash and Keystream Mode Sequencer

This block is the control unit of a dual-role engine. The same round and buffer datapath can produce a 256-bit message digest or a stream-cipher keystream. The sequencer does not hold the round state. It drives an external datapath through a two-bit command port: no operation, reset the state, push a 256-bit word into the state, or pull one round that returns a 256-bit word. It pads the message and walks one of two command schedules. In cipher mode it also combines the keystream with the payload.

A session starts when exactly one of the two role selects is high while the block is idle. In digest mode the caller streams message blocks with a valid/ready handshake and marks the last one with a bit count. The block pushes the padded blocks, runs the blank rounds, then pulls once more and presents the digest. In cipher mode the first two input beats are the key and the diversifier. After those two pushes and the blank rounds, each further input beat triggers one pull, and the XOR of the pulled word with that beat leaves on the output handshake. Encryption and decryption are the same operation. A beat flagged last ends the session.

Top module: `dualmode_seq`

## Requirements
- R1: While reset is held and just after it, `dp_cmd` is 0, `in_ready` is low and `out_valid` is low. The command codes are 0 = none, 1 = reset state, 2 = push `dp_push_word`, 3 = pull one round.
- R2: In idle, exactly one of `sel_hash`/`sel_cipher` high starts a session with exactly one reset command. If both or neither is high, the block stays idle: no command is issued and `in_ready` stays low.
- R3: In digest mode each accepted input beat is pushed once. A beat flagged `in_last` is padded: bits below `in_nbits` keep the input, bit `in_nbits` is set to 1, and all higher bits are cleared. `in_nbits` is ignored on beats that are not last.
- R4: When the last beat has `in_nbits` of 256 or more, it is pushed unchanged and is followed by one extra push of a word whose only set bit is bit 0.
- R5: After the final message push, exactly 32 pull commands run with `in_ready` low. One further pull follows, and the datapath word it returns is presented unchanged as the digest. That makes 33 pulls per digest.
- R6: In cipher mode the first accepted beat is pushed as the key and the second as the diversifier. Then 32 blank pulls run with `in_ready` low, so the first keystream pull is the 35th round after the reset.
- R7: In cipher mode each later accepted beat issues one pull, and `out_data` equals the word the datapath returns for that pull XOR the beat.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` stays stable, and no pull command is issued.
- R9: After the digest is taken, or after the output for a beat flagged `in_last` in cipher mode is taken, the block returns to idle. There it issues no command and holds `in_ready` low until a new valid select arrives.
- R10: The datapath word returned by a pull is sampled on `dp_pull_word` in the cycle after the pull command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel_hash | input | 1 | Selects the digest schedule when sampled in idle |
| sel_cipher | input | 1 | Selects the keystream schedule when sampled in idle |
| in_valid | input | 1 | Input beat offered |
| in_ready | output | 1 | Input beat accepted when high with `in_valid` |
| in_data | input | 256 | Message block, key, diversifier or payload |
| in_last | input | 1 | Last beat of the session |
| in_nbits | input | 9 | Valid message bits in the last digest beat |
| dp_cmd | output | 2 | Datapath command (0 none, 1 reset, 2 push, 3 pull) |
| dp_push_word | output | 256 | Word injected on a push command |
| dp_pull_word | input | 256 | Datapath result, valid the cycle after a pull |
| out_valid | output | 1 | Digest or processed payload offered |
| out_ready | input | 1 | Output taken when high with `out_valid` |
| out_data | output | 256 | Digest or payload XOR keystream |

## Verification
The bench goes after three tail cases of the padding: a partial last block, a last block that is exactly full, and an empty last block. A design that misplaces the marker bit or skips the extra block produces a wrong digest and a wrong push count. It checks the exact count of blank pulls before the first result, since an off-by-one counter shifts every output by one round. It applies output back-pressure during the keystream phase to catch a design that pulls while the result is held, which loses a keystream block or lets `out_data` change under a stalled handshake. It also holds both role selects and then neither, to confirm that no command leaks out of idle.

// File: rtl/dms_pkg.sv
package dms_pkg;

  typedef enum logic [1:0] {
    CMD_NONE = 2'd0,
    CMD_RST  = 2'd1,
    CMD_PUSH = 2'd2,
    CMD_PULL = 2'd3
  } dp_cmd_e;

  typedef enum logic [3:0] {
    S_IDLE,
    S_RST,
    S_ABSORB,
    S_PADX,
    S_KEY,
    S_DIV,
    S_BLANK,
    S_FINAL,
    S_STREAM,
    S_DRAIN
  } seq_state_e;

  // exactly one role requested
  function automatic logic role_ok(logic h, logic c);
    return h ^ c;
  endfunction

  // last block carries no room for the marker bit
  function automatic logic tail_full(int unsigned nbits, int unsigned width);
    return nbits >= width;
  endfunction

endpackage

// File: rtl/dms_pad.sv
module dms_pad #(
  parameter int W    = 256,
  parameter int NB_W = $clog2(W + 1)
) (
  input  logic [W-1:0]    data_i,
  input  logic            tail_i,
  input  logic [NB_W-1:0] nbits_i,
  output logic [W-1:0]    word_o
);

  for (genvar i = 0; i < W; i++) begin : g_bit
    localparam logic [NB_W-1:0] IDX = NB_W'(i);
    assign word_o[i] = !tail_i         ? data_i[i] :
                       (IDX < nbits_i) ? data_i[i] :
                       (IDX == nbits_i);
  end

endmodule

// File: rtl/dms_blank_cnt.sv
module dms_blank_cnt #(
  parameter int N  = 32,
  parameter int CW = (N > 1) ? $clog2(N) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic step,
  output logic last
);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) cnt_q <= '0;
    else if (step)     cnt_q <= cnt_q + CW'(1);
  end

  assign last = (cnt_q == CW'(N - 1));

  // R5: clearing and counting come from different schedule phases
  assert_step_clr_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> !clr);

endmodule

// File: rtl/dms_out_stage.sv
module dms_out_stage #(
  parameter int W = 256
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         launch,
  input  logic [W-1:0] mask,
  input  logic [W-1:0] dp_word,
  input  logic         out_ready,
  output logic         out_valid,
  output logic [W-1:0] out_data,
  output logic         pend,
  output logic         slot_free
);

  logic [W-1:0] hold_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend      <= 1'b0;
      hold_q    <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      pend <= launch;
      if (launch) hold_q <= mask;
      if (pend) begin
        out_valid <= 1'b1;
        out_data  <= dp_word ^ hold_q;
      end else if (out_valid && out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end

  assign slot_free = !pend && (!out_valid || out_ready);

  assert_no_overwrite_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pend |-> !out_valid);

  assert_hold_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

endmodule

// File: rtl/dualmode_seq.sv
module dualmode_seq
  import dms_pkg::*;
#(
  parameter int W       = 256,
  parameter int BLANK_N = 32,
  parameter int NB_W    = $clog2(W + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sel_hash,
  input  logic            sel_cipher,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [W-1:0]    in_data,
  input  logic            in_last,
  input  logic [NB_W-1:0] in_nbits,
  output logic [1:0]      dp_cmd,
  output logic [W-1:0]    dp_push_word,
  input  logic [W-1:0]    dp_pull_word,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [W-1:0]    out_data
);

  seq_state_e st_q, st_d;
  dp_cmd_e    cmd;
  logic       ciph_q;
  logic       mode_ok, full_tail;
  logic       launch, pend, slot_free;
  logic [W-1:0] launch_mask, padded;
  logic       cnt_clr, cnt_step, cnt_last;

  assign mode_ok   = role_ok(sel_hash, sel_cipher);
  assign full_tail = tail_full(int'(in_nbits), W);
  assign cnt_clr   = (st_q == S_RST);

  dms_pad #(.W(W), .NB_W(NB_W)) u_pad (
    .data_i (in_data),
    .tail_i (in_last),
    .nbits_i(in_nbits),
    .word_o (padded)
  );

  dms_blank_cnt #(.N(BLANK_N)) u_cnt (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (cnt_clr),
    .step (cnt_step),
    .last (cnt_last)
  );

  dms_out_stage #(.W(W)) u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .launch   (launch),
    .mask     (launch_mask),
    .dp_word  (dp_pull_word),
    .out_ready(out_ready),
    .out_valid(out_valid),
    .out_data (out_data),
    .pend     (pend),
    .slot_free(slot_free)
  );

  always_comb begin
    st_d         = st_q;
    cmd          = CMD_NONE;
    in_ready     = 1'b0;
    dp_push_word = '0;
    launch       = 1'b0;
    launch_mask  = '0;
    cnt_step     = 1'b0;
    unique case (st_q)
      S_IDLE: if (mode_ok) st_d = S_RST;
      S_RST: begin
        cmd  = CMD_RST;
        st_d = ciph_q ? S_KEY : S_ABSORB;
      end
      S_ABSORB: begin
        in_ready     = 1'b1;
        dp_push_word = padded;
        if (in_valid) begin
          cmd = CMD_PUSH;
          if (in_last) st_d = full_tail ? S_PADX : S_BLANK;
        end
      end
      S_PADX: begin
        cmd          = CMD_PUSH;
        dp_push_word = W'(1);
        st_d         = S_BLANK;
      end
      S_KEY, S_DIV: begin
        in_ready     = 1'b1;
        dp_push_word = in_data;
        if (in_valid) begin
          cmd  = CMD_PUSH;
          st_d = (st_q == S_KEY) ? S_DIV : S_BLANK;
        end
      end
      S_BLANK: begin
        cmd      = CMD_PULL;
        cnt_step = 1'b1;
        if (cnt_last) st_d = ciph_q ? S_STREAM : S_FINAL;
      end
      S_FINAL: begin
        if (slot_free) begin
          cmd    = CMD_PULL;
          launch = 1'b1;
          st_d   = S_DRAIN;
        end
      end
      S_STREAM: begin
        in_ready = slot_free;
        if (in_valid && slot_free) begin
          cmd         = CMD_PULL;
          launch      = 1'b1;
          launch_mask = in_data;
          if (in_last) st_d = S_DRAIN;
        end
      end
      S_DRAIN: if (!pend && !out_valid) st_d = S_IDLE;
      default: st_d = S_IDLE;
    endcase
  end

  assign dp_cmd = cmd;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      ciph_q <= 1'b0;
    end else begin
      st_q <= st_d;
      if (st_q == S_IDLE && mode_ok) ciph_q <= sel_cipher;
    end
  end

  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_IDLE && !mode_ok) |=> (dp_cmd == CMD_NONE && !in_ready));

  assert_single_reset_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (dp_cmd == CMD_RST) |=> (dp_cmd != CMD_RST));

  assert_push_has_data_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (dp_cmd == CMD_PUSH && st_q != S_PADX) |-> in_valid);

  assert_final_after_blank_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_FINAL) |-> ($past(dp_cmd) == CMD_PULL));

  assert_no_pull_when_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (dp_cmd == CMD_PULL && out_valid) |-> out_ready);

endmodule

// File: tb/dualmode_seq_test.sv
module dualmode_seq_test;

  localparam int CLK_P = 10;
  localparam int W     = 256;
  localparam int NB    = 9;
  localparam logic [W-1:0] PK = {8{32'h9e37_79b9}};

  logic clk = 1'b0, rst_n = 1'b0;
  logic sel_hash = 1'b0, sel_cipher = 1'b0;
  logic in_valid = 1'b0, in_ready, in_last = 1'b0;
  logic [W-1:0] in_data = '0;
  logic [NB-1:0] in_nbits = '0;
  logic [1:0] dp_cmd;
  logic [W-1:0] dp_push_word, dp_pull_word, out_data;
  logic out_valid, out_ready = 1'b1;

  int n_chk = 0, n_fail = 0;
  int n_rst = 0, n_push = 0, n_pull = 0, pulls_first = -1;
  int v_hold = 0, v_pull_held = 0, v_blank_rdy = 0, v_idle = 0;
  bit cur_cipher = 0, stall_en = 0, watch_idle = 0, reported = 0;
  logic [W-1:0] exp_q[$];
  logic [W-1:0] dp_st;

  always #(CLK_P / 2) clk = ~clk;

  dualmode_seq uut (
    .clk(clk), .rst_n(rst_n), .sel_hash(sel_hash), .sel_cipher(sel_cipher),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_last(in_last), .in_nbits(in_nbits), .dp_cmd(dp_cmd),
    .dp_push_word(dp_push_word), .dp_pull_word(dp_pull_word),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  function automatic logic [W-1:0] rnd(logic [W-1:0] s, logic [W-1:0] w);
    return {s[W-2:0], s[W-1]} ^ w;
  endfunction

  // stand-in round datapath
  always @(posedge clk) begin
    if (!rst_n) begin
      dp_st <= '0; dp_pull_word <= '0;
    end else begin
      case (dp_cmd)
        2'd1: dp_st <= '0;
        2'd2: dp_st <= rnd(dp_st, dp_push_word);
        2'd3: begin dp_st <= rnd(dp_st, PK); dp_pull_word <= rnd(dp_st, PK); end
        default: ;
      endcase
    end
  end

  task automatic check(input bit ok, input string tag, input logic [W-1:0] act,
                       input logic [W-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  // monitor and scoreboard
  bit prev_stall = 0;
  logic [W-1:0] prev_data = '0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_stall && (!out_valid || out_data != prev_data)) v_hold++;
      prev_stall = out_valid && !out_ready;
      prev_data  = out_data;
      if (out_valid && pulls_first < 0) pulls_first = n_pull;
      if (dp_cmd == 2'd3 && out_valid && !out_ready) v_pull_held++;
      if (cur_cipher && n_push == 2 && n_pull < 32 && in_ready) v_blank_rdy++;
      if (watch_idle && (dp_cmd != 2'd0 || in_ready)) v_idle++;
      case (dp_cmd)
        2'd1: n_rst++;
        2'd2: n_push++;
        2'd3: n_pull++;
        default: ;
      endcase
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) check(0, "R7 unexpected output", out_data, '0);
        else begin
          logic [W-1:0] e;
          e = exp_q.pop_front();
          check(out_data == e, cur_cipher ? "R7 keystream xor" : "R5 digest", out_data, e);
        end
      end
    end
  end

  int rdy_cnt = 0;
  always @(posedge clk) begin
    #1;
    rdy_cnt++;
    out_ready = stall_en ? ((rdy_cnt % 3) != 0) : 1'b1;
  end

  task automatic start_session(input bit ciph);
    n_rst = 0; n_push = 0; n_pull = 0; pulls_first = -1;
    cur_cipher = ciph;
    if (ciph) sel_cipher = 1'b1; else sel_hash = 1'b1;
    @(posedge clk); #1;
    sel_cipher = 1'b0; sel_hash = 1'b0;
  endtask

  task automatic send(input logic [W-1:0] d, input bit last, input int nb);
    in_valid = 1'b1; in_data = d; in_last = last; in_nbits = NB'(nb);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    @(posedge clk); #1;
    in_valid = 1'b0; in_last = 1'b0; in_nbits = '0;
  endtask

  task automatic finish_session(input string tag);
    int guard = 0;
    while (exp_q.size() != 0 && guard < 2000) begin @(posedge clk); guard++; end
    repeat (4) @(posedge clk);
    #1;
    watch_idle = 1; v_idle = 0;
    repeat (4) @(posedge clk);
    #1;
    watch_idle = 0;
    check(v_idle == 0, {tag, " R9 idle after session"}, W'(v_idle), '0);
  endtask

  function automatic logic [W-1:0] pat(int seed, int i);
    return {8{32'h1357_2468 + 32'(seed * 97 + i * 13)}} ^ (W'(seed) << (i * 9));
  endfunction

  task automatic hash_case(input int nblk, input int tail, input int seed);
    logic [W-1:0] st = '0, blk, d;
    int xtra = (tail >= 256) ? 1 : 0;
    for (int i = 0; i < nblk; i++) begin
      d = pat(seed, i);
      if (i == nblk - 1 && tail < 256)
        blk = (d & ((W'(1) << tail) - W'(1))) | (W'(1) << tail);
      else blk = d;
      st = rnd(st, blk);
    end
    if (xtra) st = rnd(st, W'(1));
    for (int k = 0; k < 33; k++) st = rnd(st, PK);
    exp_q.push_back(st);
    start_session(0);
    for (int i = 0; i < nblk; i++) send(pat(seed, i), i == nblk - 1, (i == nblk - 1) ? tail : 77);
    finish_session("hash");
    check(n_rst == 1, "R2 one reset per session", W'(n_rst), W'(1));
    check(n_push == nblk + xtra, xtra ? "R4 extra pad push" : "R3 push count",
          W'(n_push), W'(nblk + xtra));
    check(n_pull == 33, "R5 pulls per digest", W'(n_pull), W'(33));
    check(pulls_first == 33, "R5 blank pulls before digest", W'(pulls_first), W'(33));
  endtask

  task automatic cipher_case(input int nd, input int seed);
    logic [W-1:0] st = '0, key = pat(seed, 50), dv = pat(seed, 51);
    st = rnd(st, key); st = rnd(st, dv);
    for (int k = 0; k < 32; k++) st = rnd(st, PK);
    for (int i = 0; i < nd; i++) begin
      st = rnd(st, PK);
      exp_q.push_back(st ^ pat(seed, i));
    end
    v_blank_rdy = 0;
    start_session(1);
    send(key, 0, 0);
    send(dv, 0, 0);
    stall_en = 1;
    for (int i = 0; i < nd; i++) send(pat(seed, i), i == nd - 1, 0);
    finish_session("cipher");
    stall_en = 0;
    check(n_push == 2, "R6 key and diversifier pushes", W'(n_push), W'(2));
    check(pulls_first == 33, "R6 first keystream after 34 rounds", W'(pulls_first), W'(33));
    check(n_pull == 32 + nd, "R7 one pull per beat", W'(n_pull), W'(32 + nd));
    check(v_blank_rdy == 0, "R6 input closed in blank rounds", W'(v_blank_rdy), '0);
  endtask

  initial begin
    #(CLK_P * 150000);
    check(0, "watchdog", '0, '0);
    report();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check(dp_cmd == 2'd0 && !in_ready && !out_valid, "R1 reset state",
          W'({dp_cmd, in_ready, out_valid}), '0);
    rst_n = 1'b1;
    @(posedge clk); #1;
    check(dp_cmd == 2'd0 && !in_ready && !out_valid, "R1 after reset",
          W'({dp_cmd, in_ready, out_valid}), '0);

    // both selects, then neither
    sel_hash = 1'b1; sel_cipher = 1'b1; watch_idle = 1; v_idle = 0;
    repeat (6) @(posedge clk);
    #1;
    sel_hash = 1'b0; sel_cipher = 1'b0;
    repeat (4) @(posedge clk);
    #1;
    watch_idle = 0;
    check(v_idle == 0 && n_rst == 0, "R2 invalid role stays idle", W'(v_idle + n_rst), '0);

    hash_case(2, 100, 1);   // partial tail
    hash_case(1, 256, 2);   // full tail, extra block
    hash_case(3, 0, 3);     // empty tail
    cipher_case(5, 4);
    cipher_case(1, 5);

    check(v_hold == 0, "R8 output held under stall", W'(v_hold), '0);
    check(v_pull_held == 0, "R8 no pull while held", W'(v_pull_held), '0);
    check(exp_q.size() == 0, "R10 all results delivered", W'(exp_q.size()), '0);
    report();
  end

endmodule